// File: doc/BRIEF.md
# Two-Input Fuzzy Frequency-Level Estimator

This block turns two 8-bit measurements of a router into a 16-bit frequency-level code. The measurements are the current traffic load and how fast that load is changing. It uses zero-order Takagi-Sugeno inference. Each input is graded against a set of piecewise-linear membership functions. The grades come from rise and fall start points and slopes, so no lookup memory is needed. Every pairing of a load term with a rate term forms one rule, and the rule's firing strength is the smaller of its two grades. Each rule carries a constant output level. The result is the strength-weighted mean of those levels, scaled to fill 16 bits.

The engine is a three-stage pipeline. The first stage registers the inputs. The second stage grades the inputs, fires the rules and registers the weighted sum and the weight sum. The third stage registers the quotient from an unrolled restoring divider. A new input pair can be accepted on every clock, and the result is tagged with a one-cycle valid pulse. A downstream supply controller maps the code to a voltage and clock setting; that controller is not part of this block.

Top module: `fuzzy_vf_engine`

## Requirements
- R1: While `rstN` is low, `outValid` and `result` are 0.
- R2: A pair sampled on a rising edge with `inValid` high produces `outValid` high after the third rising edge, counting the sampling edge as the first. The pipeline accepts one pair on every clock and produces one `outValid` cycle per accepted pair.
- R3: In any cycle where `outValid` is low, `result` keeps the last computed value.
- R4: Load term k (k = 0..4, ordered very low to very high) rises from 32k with slope 8 and falls from 32k+32 with slope 8. Its grade is 0 below the rise point, min(255, (x − rise)·8) before the fall point, and max(0, 255 − (x − fall)·8) from the fall point on.
- R5: Rate terms use slope 17 (0x11) on both edges. Slow rises at 0x00 and falls at 0x0F. Normal rises at 0x0F and falls at 0x1E. Fast rises at 0x1E, holds 255 from 0x2D through 0x3C, and falls from 0x3C.
- R6: There are 15 rules, one for each (load term t, rate term d). A rule's weight is min(load grade, rate grade). Its level is 0x20 when t+d ≤ 1, 0x80 when t+d is 2 or 3, and 0xE0 when t+d ≥ 4.
- R7: `result` = floor(Σ(weight·level)·256 / Σweight).
- R8: When every weight is zero, `result` is 0. This happens when the load is 0x00 or at least 0xC0, when the rate is 0x00 or at least 0x4B, or in any other case where no rule fires.
- R9: A valid `result` is either 0 or lies in the range 0x2000 to 0xE000 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Marks a new load/rate pair to evaluate |
| trafficIn | input | 8 | Traffic load measurement |
| rateIn | input | 8 | Magnitude of the change in traffic load |
| outValid | output | 1 | One-cycle pulse marking a fresh result |
| result | output | 16 | Weighted-mean frequency-level code |

## Verification
The latency property compares `outValid` with `inValid` from three cycles earlier. It assumes `inValid` is always driven to a known 0 or 1, and it starts checking only once three cycles have passed since reset. The zero-result property assumes the default term placement, so a load of 0xC0 or above, or a rate of 0x4B or above, means no rule fires. The stimulus changes inputs only on falling edges and keeps `inValid` low during reset. Random rates are drawn mostly within 0x00–0x4F, so the fast term's falling edge and the empty region beyond it are both exercised. Loads cover the full 8-bit range.

// File: rtl/fuzzy_pkg.sv
package fuzzy_pkg;
  localparam int DegW         = 8;
  localparam int NumLoadTerms = 5;
  localparam int NumRateTerms = 3;
  localparam int NumRules     = NumLoadTerms * NumRateTerms;
  localparam int LoadStep     = 32;
  localparam int LoadSlope    = 8;
  localparam int RateStep     = 15;
  localparam int RateSlope    = 17;
  localparam logic [DegW-1:0] LevelLow  = 8'h20;
  localparam logic [DegW-1:0] LevelMid  = 8'h80;
  localparam logic [DegW-1:0] LevelHigh = 8'hE0;

  typedef struct packed {
    logic [DegW-1:0] riseStart;
    logic [DegW-1:0] riseSlope;
    logic [DegW-1:0] fallStart;
    logic [DegW-1:0] fallSlope;
  } mf_param_t;

  typedef struct packed {
    logic capEn;
    logic sumEn;
    logic divEn;
  } fuzzy_strobe_t;

  function automatic mf_param_t loadTerm(int k);
    mf_param_t p;
    p.riseStart = DegW'(k * LoadStep);
    p.riseSlope = DegW'(LoadSlope);
    p.fallStart = DegW'((k + 1) * LoadStep);
    p.fallSlope = DegW'(LoadSlope);
    return p;
  endfunction

  // the top rate term carries a plateau one grid step wide
  function automatic mf_param_t rateTerm(int k);
    mf_param_t p;
    p.riseStart = DegW'(k * RateStep);
    p.riseSlope = DegW'(RateSlope);
    p.fallStart = (k == NumRateTerms - 1) ? DegW'((k + 2) * RateStep)
                                          : DegW'((k + 1) * RateStep);
    p.fallSlope = DegW'(RateSlope);
    return p;
  endfunction

  function automatic logic [DegW-1:0] ruleLevel(int t, int d);
    if (t + d <= 1)      return LevelLow;
    else if (t + d <= 3) return LevelMid;
    else                 return LevelHigh;
  endfunction
endpackage

// File: rtl/fuzzy_member.sv
module fuzzy_member
  import fuzzy_pkg::*;
#(
  parameter mf_param_t Shape = '0
) (
  input  logic [DegW-1:0] x,
  output logic [DegW-1:0] degree
);
  localparam int ProdW = 2 * DegW;
  localparam logic [ProdW-1:0] DegMax = ProdW'((1 << DegW) - 1);

  logic [DegW-1:0]  riseDist, fallDist;
  logic [ProdW-1:0] riseProd, fallProd;

  always_comb begin
    riseDist = x - Shape.riseStart;
    fallDist = x - Shape.fallStart;
    riseProd = {{DegW{1'b0}}, riseDist} * {{DegW{1'b0}}, Shape.riseSlope};
    fallProd = {{DegW{1'b0}}, fallDist} * {{DegW{1'b0}}, Shape.fallSlope};
    if (x < Shape.riseStart) begin
      degree = '0;
    end else if (x < Shape.fallStart) begin
      degree = (riseProd > DegMax) ? DegMax[DegW-1:0] : riseProd[DegW-1:0];
    end else begin
      degree = (fallProd >= DegMax) ? '0 : DegW'(DegMax - fallProd);
    end
  end
endmodule

// File: rtl/fuzzy_divider.sv
module fuzzy_divider #(
  parameter int NumW   = 20,
  parameter int DenW   = 12,
  parameter int QuoW   = 16,
  parameter int ShiftW = 8
) (
  input  logic [NumW-1:0] num,
  input  logic [DenW-1:0] den,
  output logic [QuoW-1:0] quo
);
  localparam int DivW = NumW + ShiftW;

  logic [DivW-1:0] rem [QuoW];

  assign rem[0] = {num, {ShiftW{1'b0}}};

  for (genvar b = 0; b < QuoW; b++) begin : g_step
    localparam int Sh = QuoW - 1 - b;
    logic [DivW-1:0] trial;
    assign trial   = DivW'(den) << Sh;
    assign quo[Sh] = (den != '0) && (rem[b] >= trial);
    if (b < QuoW - 1) begin : g_next
      assign rem[b+1] = quo[Sh] ? rem[b] - trial : rem[b];
    end
  end
endmodule

// File: rtl/fuzzy_ctrl.sv
module fuzzy_ctrl
  import fuzzy_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output fuzzy_strobe_t strobe,
  output logic          outValid
);
  logic [1:0] stageValid;
  logic       doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= '0;
      doneQ      <= 1'b0;
    end else begin
      stageValid <= {stageValid[0], inValid};
      doneQ      <= stageValid[1];
    end
  end

  assign strobe.capEn = inValid;
  assign strobe.sumEn = stageValid[0];
  assign strobe.divEn = stageValid[1];
  assign outValid     = doneQ;
endmodule

// File: rtl/fuzzy_datapath.sv
module fuzzy_datapath
  import fuzzy_pkg::*;
#(
  parameter int OutW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  fuzzy_strobe_t   strobe,
  input  logic [DegW-1:0] trafficIn,
  input  logic [DegW-1:0] rateIn,
  output logic [OutW-1:0] result
);
  localparam int RuleCntW = $clog2(NumRules + 1);
  localparam int DenW     = DegW + RuleCntW;
  localparam int NumW     = 2 * DegW + RuleCntW;
  localparam int ScaleW   = OutW - DegW;

  logic [DegW-1:0] trafficQ, rateQ;
  logic [DegW-1:0] loadDeg [NumLoadTerms];
  logic [DegW-1:0] rateDeg [NumRateTerms];
  logic [DegW-1:0] weight;
  logic [NumW-1:0] numSum, numQ;
  logic [DenW-1:0] denSum, denQ;
  logic [OutW-1:0] quotient, resultQ;

  for (genvar k = 0; k < NumLoadTerms; k++) begin : g_load
    fuzzy_member #(.Shape(loadTerm(k))) member_i (.x(trafficQ), .degree(loadDeg[k]));
  end

  for (genvar k = 0; k < NumRateTerms; k++) begin : g_rate
    fuzzy_member #(.Shape(rateTerm(k))) member_i (.x(rateQ), .degree(rateDeg[k]));
  end

  always_comb begin
    numSum = '0;
    denSum = '0;
    weight = '0;
    for (int t = 0; t < NumLoadTerms; t++) begin
      for (int d = 0; d < NumRateTerms; d++) begin
        weight = (loadDeg[t] < rateDeg[d]) ? loadDeg[t] : rateDeg[d];
        numSum = numSum + NumW'(weight) * NumW'(ruleLevel(t, d));
        denSum = denSum + DenW'(weight);
      end
    end
  end

  fuzzy_divider #(
    .NumW(NumW), .DenW(DenW), .QuoW(OutW), .ShiftW(ScaleW)
  ) divider_i (
    .num(numQ), .den(denQ), .quo(quotient)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trafficQ <= '0;
      rateQ    <= '0;
      numQ     <= '0;
      denQ     <= '0;
      resultQ  <= '0;
    end else begin
      if (strobe.capEn) begin
        trafficQ <= trafficIn;
        rateQ    <= rateIn;
      end
      if (strobe.sumEn) begin
        numQ <= numSum;
        denQ <= denSum;
      end
      if (strobe.divEn) resultQ <= quotient;
    end
  end

  assign result = resultQ;
endmodule

// File: rtl/fuzzy_vf_engine.sv
module fuzzy_vf_engine
  import fuzzy_pkg::*;
#(
  parameter int OutW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [DegW-1:0] trafficIn,
  input  logic [DegW-1:0] rateIn,
  output logic            outValid,
  output logic [OutW-1:0] result
);
  fuzzy_strobe_t strobe;

  fuzzy_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  fuzzy_datapath #(.OutW(OutW)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .trafficIn(trafficIn), .rateIn(rateIn), .result(result)
  );
endmodule

// File: rtl/fuzzy_vf_engine_chk.sv
module fuzzy_vf_engine_chk
  import fuzzy_pkg::*;
#(
  parameter int OutW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [DegW-1:0] trafficIn,
  input logic [DegW-1:0] rateIn,
  input logic            outValid,
  input logic [OutW-1:0] result
);
  localparam int ScaleW = OutW - DegW;
  localparam int LoadEmpty = (NumLoadTerms + 1) * LoadStep;
  localparam int RateEmpty = (NumRateTerms + 2) * RateStep;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && !outValid) |-> $stable(result));

  // R8
  empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && outValid && $past(inValid, 3) &&
     (int'($past(trafficIn, 3)) >= LoadEmpty || int'($past(rateIn, 3)) >= RateEmpty))
    |-> (result == '0));

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (result == '0 ||
      (result >= (OutW'(LevelLow) << ScaleW) && result <= (OutW'(LevelHigh) << ScaleW))));
endmodule

bind fuzzy_vf_engine fuzzy_vf_engine_chk #(.OutW(OutW)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .trafficIn(trafficIn),
  .rateIn(rateIn), .outValid(outValid), .result(result)
);

// File: tb/fuzzy_vf_engine_tb_top.sv
module fuzzy_vf_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  trafficIn = '0;
  logic [7:0]  rateIn = '0;
  logic        outValid;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit    histV [3];
  int    histE [3];
  string histT [3];
  int    lastExp = 0;

  always #4 clk = ~clk;

  fuzzy_vf_engine dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .trafficIn(trafficIn),
    .rateIn(rateIn), .outValid(outValid), .result(result)
  );

  function automatic int grade(int x, int p1, int s1, int p2, int s2);
    int v;
    if (x < p1) return 0;
    if (x < p2) begin
      v = (x - p1) * s1;
      return (v > 255) ? 255 : v;
    end
    v = 255 - (x - p2) * s2;
    return (v < 0) ? 0 : v;
  endfunction

  // R4 load terms, R5 rate terms, R6 rules, R7 quotient, R8 empty case
  function automatic int refResult(int t, int r);
    int lg [5];
    int rg [3];
    int num = 0;
    int den = 0;
    int w, lvl;
    for (int k = 0; k < 5; k++) lg[k] = grade(t, 32 * k, 8, 32 * k + 32, 8);
    rg[0] = grade(r, 0, 17, 15, 17);
    rg[1] = grade(r, 15, 17, 30, 17);
    rg[2] = grade(r, 30, 17, 60, 17);
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 3; b++) begin
        w = (lg[a] < rg[b]) ? lg[a] : rg[b];
        lvl = (a + b <= 1) ? 32 : ((a + b <= 3) ? 128 : 224);
        num += w * lvl;
        den += w;
      end
    end
    if (den == 0) return 0;
    return (num * 256) / den;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic step(bit v, int t, int r, string tag);
    @(negedge clk);
    if (histV[2]) begin
      check(outValid === 1'b1, "R2", int'(outValid), 1);
      check(int'(result) == histE[2], histT[2], int'(result), histE[2]);
      lastExp = histE[2];
    end else begin
      check(outValid === 1'b0, "R2", int'(outValid), 0);
      check(int'(result) == lastExp, "R3", int'(result), lastExp);
    end
    histV[2] = histV[1]; histE[2] = histE[1]; histT[2] = histT[1];
    histV[1] = histV[0]; histE[1] = histE[0]; histT[1] = histT[0];
    histV[0] = v;
    histE[0] = v ? refResult(t, r) : 0;
    histT[0] = tag;
    inValid   = v;
    trafficIn = 8'(t);
    rateIn    = 8'(r);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    for (int i = 0; i < 3; i++) begin histV[i] = 1'b0; histE[i] = 0; histT[i] = "R2"; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outValid === 1'b0, "R1", int'(outValid), 0);
      check(result === 16'h0, "R1", int'(result), 0);
    end
    rstN = 1'b1;
    step(1, 8'h40, 8'h1E, "R4");   // single rule low/normal -> 0x8000
    step(1, 8'h20, 8'h0F, "R9");   // lowest level -> 0x2000
    step(1, 8'hA0, 8'h3C, "R9");   // highest level -> 0xE000
    step(0, 8'h00, 8'h00, "R3");
    step(1, 8'h00, 8'h10, "R8");   // load at zero: nothing fires
    step(1, 8'hC5, 8'h20, "R8");   // load beyond last term
    step(1, 8'h60, 8'h80, "R8");   // rate beyond fast term
    step(1, 8'h28, 8'h28, "R7");   // mixed four-rule average
    step(1, 8'h30, 8'h2D, "R6");   // fast at full grade, two load terms
    step(1, 8'h60, 8'h3C, "R5");   // fast plateau end
    step(1, 8'h30, 8'h00, "R5");   // slow at zero grade
    step(0, 8'h11, 8'h22, "R3");
    step(0, 8'h33, 8'h44, "R3");
    for (int n = 0; n < 400; n++) begin
      bit v;
      int t, r;
      v = ($urandom % 4) != 0;
      t = $urandom % 256;
      r = (($urandom % 8) == 0) ? ($urandom % 256) : ($urandom % 80);
      step(v, t, r, "R7");
    end
    for (int n = 0; n < 4; n++) step(0, 0, 0, "R3");
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule